// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block is a serial TDM channel switch. It receives several bit-serial input streams. Each stream is cut into frames of 8-bit channels, one byte per channel per frame. The block stores every received byte in a two-bank data store. For every output stream and channel, it then transmits a byte chosen by a per-channel routing entry. An entry either names a source (input stream plus channel) or holds a literal byte that the host wants sent in that slot.

A frame pulse marks the frame edge. One bit is carried per clock, most significant bit first. All streams share one rate, picked by a configuration register: 32, 64, 128 or 256 channels per frame. These counts match a 125 µs frame at 2.048, 4.096, 8.192 and 16.384 Mbps.

A small host port writes routing entries and the rate, reads routing entries back, and reads any byte received in the last complete frame. The port has a 14-bit address and 16-bit data.

Top module: `tsi_switch`

## Requirements
- R1: A byte received on input stream s in channel c during frame n is sent during frame n+1 on every output channel whose active entry names source (s, c). Bit k of output channel j (k=0 is the MSB) appears in cycle 8*j+k after the frame edge.
- R2: An active entry with bit 15 set is in literal mode. Its low byte is sent on that output channel in place of switched data.
- R3: A routing write made during frame n leaves the output of frame n unchanged and applies to the whole of frame n+1.
- R4: A host read with address bits [13:12]=10 returns, one cycle later with the valid strobe high, the byte received in the previous frame on stream addr[9:8], channel addr[7:0], in data bits [7:0].
- R5: Writing address 0x3000 sets the rate code from data bits [1:0]. Codes 0, 1, 2 and 3 give 32, 64, 128 and 256 channels per frame. The switching of R1 and R2 holds at every rate.
- R6: During reset, and in any channel slot past the last channel of the frame, the outputs are all ones.
- R7: A frame pulse high in one clock cycle makes the next cycle bit 7 (the MSB) of channel 0.
- R8: A host write with address bit 13 clear stores a routing entry for output stream addr[9:8], channel addr[7:0]. The entry has data bit 15 as the literal flag, bits [9:8] as the source stream, and bits [7:0] as the source channel or literal byte. A host read of the same address returns the last written entry, with bits [14:10] zero.
- R9: The one-frame delay of R1 also holds when the source is the last channel of the frame and the destination is channel 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| framePulse | input | 1 | High for one cycle at the last bit of a frame |
| rxIn | input | 4 | Serial input streams |
| txOut | output | 4 | Serial output streams |
| hostAddr | input | 14 | Host address |
| hostWrData | input | 16 | Host write data |
| hostWe | input | 1 | Host write strobe |
| hostRe | input | 1 | Host read strobe |
| hostRdData | output | 16 | Host read data |
| hostRdValid | output | 1 | Read data valid, one cycle after hostRe |

## Verification
An output bit is due in the cycle just after the register edge that loads the output shifter. So the byte for channel j is due across cycles 8*j to 8*j+7 counted from the frame edge, and it carries data captured one whole frame earlier. A host read is due exactly one cycle after its strobe. A routing write is due to take effect only at the next frame edge.

The bench keeps its own count of cycles from each frame pulse. It samples every output bit at the falling edge of the cycle it belongs to. It compares each assembled byte with a model made of the previous frame's input and the routing table as it stood when the previous frame ended. Each read result is compared in the one cycle after the strobe.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int NUM_ST = 4;
  localparam int MAX_CH = 256;
  localparam int STW    = $clog2(NUM_ST);
  localparam int CHW    = $clog2(MAX_CH);
  localparam int POSW   = $clog2(MAX_CH * 8);
  localparam int ADDRW  = 14;
  localparam int DATAW  = 16;
  localparam int PADW   = DATAW - 1 - STW - CHW;

  typedef struct packed {
    logic           msg;
    logic [STW-1:0] src;
    logic [CHW-1:0] chan;
  } cmEntry_t;

  typedef struct packed {
    logic           captureByte;
    logic           fetchEntry;
    logic           loadTx;
    logic           loadValid;
    logic           commit;
    logic           wrBank;
    logic           readBank;
    logic           cmWr;
    logic           cmRd;
    logic           dmRd;
    logic [CHW-1:0] curCh;
    logic [CHW-1:0] fetchCh;
    logic [STW-1:0] hostSt;
    logic [CHW-1:0] hostCh;
  } strobe_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  logic             hostWe,
  input  logic             hostRe,
  input  logic [ADDRW-1:0] hostAddr,
  input  logic [1:0]       cfgData,
  output strobe_t          stb
);
  localparam int BASECH = MAX_CH / 8;

  logic [POSW-1:0] pos;
  logic            wrBank;
  logic [1:0]      rate;
  logic [CHW:0]    chans, lastCh, chNext;
  logic [CHW-1:0]  ch;
  logic [2:0]      bitIdx;
  logic [POSW:0]   commitPos;
  logic            inFrame, isCm, isDm, isCfg;
  logic            unusedAddrBits;

  assign unusedAddrBits = ^hostAddr[ADDRW-3:CHW+STW];

  assign chans     = (CHW+1)'(BASECH) << rate;
  assign lastCh    = chans - 1'b1;
  assign ch        = pos[POSW-1:3];
  assign bitIdx    = pos[2:0];
  assign chNext    = {1'b0, ch} + 1'b1;
  assign inFrame   = {1'b0, ch} < chans;
  assign commitPos = {chans, 3'b000} - (POSW+1)'(9);

  assign isCm  = !hostAddr[ADDRW-1];
  assign isDm  = hostAddr[ADDRW-1 -: 2] == 2'b10;
  assign isCfg = hostAddr[ADDRW-1 -: 2] == 2'b11;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos    <= '0;
      wrBank <= 1'b0;
      rate   <= 2'd0;
    end else begin
      pos <= framePulse ? '0 : pos + 1'b1;
      if (framePulse) wrBank <= ~wrBank;
      if (hostWe && isCfg) rate <= cfgData;
    end
  end

  always_comb begin
    stb.captureByte = (bitIdx == 3'd7) && inFrame;
    stb.fetchEntry  = (bitIdx == 3'd0) && inFrame;
    stb.fetchCh     = ({1'b0, ch} == lastCh) ? '0 : chNext[CHW-1:0];
    stb.loadTx      = (bitIdx == 3'd7) || framePulse;
    stb.loadValid   = framePulse || (chNext < chans);
    stb.commit      = ({1'b0, pos} == commitPos);
    stb.wrBank      = wrBank;
    stb.readBank    = framePulse ? wrBank : ~wrBank;
    stb.curCh       = ch;
    stb.cmWr        = hostWe && isCm;
    stb.cmRd        = hostRe && isCm;
    stb.dmRd        = hostRe && isDm;
    stb.hostSt      = hostAddr[CHW+STW-1:CHW];
    stb.hostCh      = hostAddr[CHW-1:0];
  end

  // R3
  single_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !stb.commit);

  // R7
  pulse_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |-> (stb.loadTx && stb.loadValid && (stb.readBank == stb.wrBank)));

  // R5
  chans_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(chans) == 1);
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [NUM_ST-1:0] rxIn,
  input  cmEntry_t          wrEntry,
  output logic [NUM_ST-1:0] txOut,
  output logic [DATAW-1:0]  hostRdData,
  output logic              hostRdValid
);
  logic [7:0] dm     [2][NUM_ST][MAX_CH];
  cmEntry_t   cmShd  [NUM_ST][MAX_CH];
  cmEntry_t   cmAct  [NUM_ST][MAX_CH];
  logic [7:0] rxShift [NUM_ST];
  logic [7:0] rxByte  [NUM_ST];
  cmEntry_t   entryReg [NUM_ST];
  logic [7:0] txShift  [NUM_ST];
  logic [7:0] srcByte  [NUM_ST];

  for (genvar s = 0; s < NUM_ST; s++) begin : g_rx
    assign rxByte[s] = {rxShift[s][6:0], rxIn[s]};
    always_ff @(posedge clk) begin
      if (!rstN) rxShift[s] <= '0;
      else       rxShift[s] <= rxByte[s];
    end
  end

  always_ff @(posedge clk) begin
    if (stb.captureByte)
      for (int s = 0; s < NUM_ST; s++)
        dm[stb.wrBank][s][stb.curCh] <= rxByte[s];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int o = 0; o < NUM_ST; o++)
        for (int c = 0; c < MAX_CH; c++) begin
          cmShd[o][c] <= '0;
          cmAct[o][c] <= '0;
        end
    end else begin
      if (stb.cmWr) cmShd[stb.hostSt][stb.hostCh] <= wrEntry;
      if (stb.commit) cmAct <= cmShd;
    end
  end

  for (genvar o = 0; o < NUM_ST; o++) begin : g_tx
    always_comb begin
      if (entryReg[o].msg)
        srcByte[o] = entryReg[o].chan;
      else if ((stb.readBank == stb.wrBank) && (entryReg[o].chan == stb.curCh))
        srcByte[o] = rxByte[entryReg[o].src];
      else
        srcByte[o] = dm[stb.readBank][entryReg[o].src][entryReg[o].chan];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryReg[o] <= '0;
        txShift[o]  <= '1;
      end else begin
        if (stb.fetchEntry) entryReg[o] <= cmAct[o][stb.fetchCh];
        if (stb.loadTx) txShift[o] <= stb.loadValid ? srcByte[o] : 8'hFF;
        else            txShift[o] <= {txShift[o][6:0], 1'b1};
      end
    end

    assign txOut[o] = txShift[o][7];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdValid <= 1'b0;
      hostRdData  <= '0;
    end else begin
      hostRdValid <= stb.cmRd || stb.dmRd;
      if (stb.cmRd)
        hostRdData <= {cmShd[stb.hostSt][stb.hostCh].msg, {PADW{1'b0}},
                       cmShd[stb.hostSt][stb.hostCh].src,
                       cmShd[stb.hostSt][stb.hostCh].chan};
      else if (stb.dmRd)
        hostRdData <= {{(DATAW-8){1'b0}}, dm[~stb.wrBank][stb.hostSt][stb.hostCh]};
      else
        hostRdData <= '0;
    end
  end

  // R6
  idle_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && !stb.loadValid) |=> (&txOut));

  // R2
  msg_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadTx && stb.loadValid && entryReg[0].msg) |=> (txShift[0] == $past(entryReg[0].chan)));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              framePulse,
  input  logic [NUM_ST-1:0] rxIn,
  output logic [NUM_ST-1:0] txOut,
  input  logic [ADDRW-1:0]  hostAddr,
  input  logic [DATAW-1:0]  hostWrData,
  input  logic              hostWe,
  input  logic              hostRe,
  output logic [DATAW-1:0]  hostRdData,
  output logic              hostRdValid
);
  strobe_t  stb;
  cmEntry_t wrEntry;
  logic     unusedWrBits;

  assign unusedWrBits = ^hostWrData[DATAW-2:CHW+STW];
  assign wrEntry = '{msg:  hostWrData[DATAW-1],
                     src:  hostWrData[CHW+STW-1:CHW],
                     chan: hostWrData[CHW-1:0]};

  tsi_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .framePulse(framePulse),
    .hostWe    (hostWe),
    .hostRe    (hostRe),
    .hostAddr  (hostAddr),
    .cfgData   (hostWrData[1:0]),
    .stb       (stb)
  );

  tsi_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rxIn       (rxIn),
    .wrEntry    (wrEntry),
    .txOut      (txOut),
    .hostRdData (hostRdData),
    .hostRdValid(hostRdValid)
  );
endmodule

// File: tb/sim_tsi_switch.sv
`timescale 1ns/1ps
module sim_tsi_switch;
  import tsi_pkg::*;

  logic clk = 0, rstN = 0, framePulse = 0;
  logic [NUM_ST-1:0] rxIn = '0;
  wire  [NUM_ST-1:0] txOut;
  logic [13:0] hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic hostWe = 0, hostRe = 0;
  wire  [15:0] hostRdData;
  wire  hostRdValid;

  tsi_switch u0 (.clk(clk), .rstN(rstN), .framePulse(framePulse), .rxIn(rxIn),
                 .txOut(txOut), .hostAddr(hostAddr), .hostWrData(hostWrData),
                 .hostWe(hostWe), .hostRe(hostRe), .hostRdData(hostRdData),
                 .hostRdValid(hostRdValid));

  always #2.5 clk = ~clk;

  int passCnt = 0, failCnt = 0;
  bit done = 0;
  int frameLen = 256, chansB = 32, rateB = 0;

  logic [7:0]  rxCur  [NUM_ST][MAX_CH];
  logic [7:0]  rxPrev [NUM_ST][MAX_CH];
  logic [15:0] cmShdM [NUM_ST][MAX_CH];
  logic [15:0] cmActM [NUM_ST][MAX_CH];
  bit          touched[NUM_ST][MAX_CH];
  logic [13:0] pAddr[16];
  logic [15:0] pData[16];
  int nPend = 0;
  int rdK = -1;
  logic [13:0] rdAddr;
  logic [15:0] rdExp;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expOut(input int o, input int c);
    logic [15:0] e = cmActM[o][c];
    return e[15] ? e[7:0] : rxPrev[e[9:8]][e[7:0]];
  endfunction

  task automatic fillRx();
    for (int s = 0; s < NUM_ST; s++)
      for (int c = 0; c < MAX_CH; c++) rxCur[s][c] = 8'($urandom);
  endtask

  task automatic addWrite(input int o, input int c, input bit msg, input int src, input int val);
    pAddr[nPend] = {4'b0000, 2'(o), 8'(c)};
    pData[nPend] = {msg, 5'b00000, 2'(src), 8'(val)};
    nPend++;
  endtask

  task automatic addRandomWrites(input int n);
    for (int i = 0; i < n; i++)
      addWrite($urandom_range(0, 3), $urandom_range(0, chansB - 1),
               ($urandom_range(0, 3) == 0), $urandom_range(0, 3),
               $urandom_range(0, chansB - 1));
  endtask

  task automatic setRandomRead();
    rdK = frameLen / 2;
    if ($urandom_range(0, 1) == 1)
      rdAddr = {2'b10, 2'b00, 2'($urandom_range(0, 3)), 8'($urandom_range(0, chansB - 1))};
    else
      rdAddr = {4'b0000, 2'($urandom_range(0, 3)), 8'($urandom_range(0, chansB - 1))};
  endtask

  task automatic runFrame(input int extra, input bit doCheck);
    int total = frameLen + extra;
    logic [7:0] got [NUM_ST];
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      for (int o = 0; o < NUM_ST; o++) got[o] = {got[o][6:0], txOut[o]};
      if (doCheck && (k % 8 == 7)) begin
        for (int o = 0; o < NUM_ST; o++) begin
          int c = k / 8;
          logic [7:0] exp;
          string tag;
          if (k < frameLen) begin
            logic [15:0] e = cmActM[o][c];
            exp = expOut(o, c);
            if (c == 0 && !e[15] && e[7:0] == 8'(chansB - 1)) tag = "R9";
            else if (touched[o][c]) tag = "R3";
            else if (rateB != 0) tag = "R5";
            else if (e[15]) tag = "R2";
            else if (c == 0) tag = "R7";
            else tag = "R1";
          end else begin
            exp = 8'hFF;
            tag = "R6";
          end
          check(got[o] == exp, tag, got[o], exp);
        end
      end
      if (rdK >= 0 && k == rdK + 1)
        check(hostRdValid && hostRdData == rdExp, rdAddr[13] ? "R4" : "R8",
              hostRdData, rdExp);
      for (int s = 0; s < NUM_ST; s++)
        rxIn[s] = (k < frameLen) ? rxCur[s][k / 8][7 - (k % 8)] : 1'b0;
      hostWe = 0;
      hostRe = 0;
      if (k >= 8 && k < 8 + nPend) begin
        hostWe = 1;
        hostAddr = pAddr[k - 8];
        hostWrData = pData[k - 8];
        if (!pAddr[k - 8][13]) begin
          cmShdM[pAddr[k - 8][9:8]][pAddr[k - 8][7:0]] = pData[k - 8];
          touched[pAddr[k - 8][9:8]][pAddr[k - 8][7:0]] = 1;
        end
      end else if (k == rdK) begin
        hostRe = 1;
        hostAddr = rdAddr;
        rdExp = rdAddr[13] ? {8'h00, rxPrev[rdAddr[9:8]][rdAddr[7:0]]}
                           : cmShdM[rdAddr[9:8]][rdAddr[7:0]];
      end
      framePulse = (k == total - 1);
    end
    rxPrev = rxCur;
    cmActM = cmShdM;
    for (int o = 0; o < NUM_ST; o++)
      for (int c = 0; c < MAX_CH; c++) touched[o][c] = 0;
    fillRx();
    nPend = 0;
    rdK = -1;
  endtask

  task automatic changeRate(input int code);
    pAddr[0] = 14'h3000;
    pData[0] = 16'(code);
    nPend = 1;
    runFrame(0, 0);
    rateB = code;
    chansB = 32 << code;
    frameLen = chansB * 8;
    runFrame(0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int o = 0; o < NUM_ST; o++)
      for (int c = 0; c < MAX_CH; c++) begin
        cmShdM[o][c] = '0;
        cmActM[o][c] = '0;
        touched[o][c] = 0;
      end
    fillRx();
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R6: outputs idle high in reset
    check(txOut == 4'hF, "R6", txOut, 4'hF);
    check(!hostRdValid, "R4", hostRdValid, 0);
    rstN = 1;

    runFrame(0, 0);                         // sync on first pulse
    addWrite(1, 0, 0, 3, 31);               // R9: last channel to channel 0
    addWrite(0, 31, 1, 0, 8'hA5);           // R2: literal in last slot
    addWrite(2, 5, 0, 1, 5);
    addWrite(3, 0, 1, 0, 8'h00);
    addWrite(2, 31, 0, 2, 0);
    rdK = 100;
    rdAddr = {4'b0000, 2'd0, 8'd31};        // R8 readback
    runFrame(0, 0);

    for (int f = 0; f < 6; f++) begin
      addRandomWrites(6);
      if (f == 2) addWrite(1, 0, 1, 0, 8'h3C); // R3 mid-frame overwrite
      setRandomRead();
      runFrame(0, 1);
    end

    runFrame(16, 1);                        // R6 idle slots past frame end
    setRandomRead();
    runFrame(0, 1);

    changeRate(1);                          // R5: 64 channels
    for (int f = 0; f < 3; f++) begin
      addRandomWrites(8);
      setRandomRead();
      runFrame(0, 1);
    end

    changeRate(3);                          // R5: 256 channels
    addWrite(0, 0, 0, 1, 255);              // R9 at full rate
    addRandomWrites(10);
    setRandomRead();
    runFrame(0, 1);
    setRandomRead();
    runFrame(0, 1);

    done = 1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule